// File: doc/BRIEF.md
# Least-Recently-Issued Context Tracker

This block watches instruction issue across the hardware thread contexts of a multithreaded core and keeps them in recency order, oldest first. The context at the oldest end is the one picked for background register save and restore to its swap page. A request for that transfer is raised only when the memory port has a spare cycle and the chosen context holds unsaved register state.

The block also decides when a blocked core should tell its event-handling software that it is stuck. It raises a one-cycle stall event when no context can issue and the oldest context has nothing left to save. It does not suspend anything. Context 0 belongs to the microkernel. It is never chosen for background transfer and does not take part in the recency order.

A three-state machine controls the event:
- ST_ARMED (the reset state) moves to ST_EVENT when the stall condition holds.
- ST_EVENT drives the pulse for exactly one cycle. It then moves to ST_ARMED if an issue was seen in that cycle, and to ST_WAIT otherwise.
- ST_WAIT moves back to ST_ARMED on the first issue strobe.

Top module: `lri_ctx_tracker`

## Requirements
- R1: After reset the oldest context is 1 and the order from oldest to newest is 1, 2, …, NUM_CTX-1. Every context is clean, `stall_evt` is 0, and `dribble_req` is 0 whatever `spare_cycle` is.
- R2: When `issue_vld` is 1 with `issue_ctx` = c, where c is in 1..NUM_CTX-1, c moves to the newest end from the next cycle on. Contexts that were newer than c each move one place towards the oldest end. `lri_ctx` always shows the oldest entry.
- R3: An issue strobe for context 0 leaves the order unchanged, and `lri_ctx` never shows 0.
- R4: Each context's unsaved-state flag is set by bit c of `dirty_set`. It is cleared for the current oldest context by `xfer_done`. A set and a clear on the same context in the same cycle leave it set. Bit 0 of `dirty_set` has no effect.
- R5: `dribble_req` equals `spare_cycle` AND the flag of `lri_ctx`, in the same cycle.
- R6: If `can_issue` is all zeros and the flag of `lri_ctx` is clear in cycle t while the machine is in ST_ARMED, then `stall_evt` is 1 in cycle t+1. `stall_evt` is never 1 in any other case.
- R7: `stall_evt` lasts exactly one cycle. After a pulse, no further pulse comes until an issue strobe has been seen, either during the pulse cycle or later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_vld | input | 1 | An instruction issued this cycle |
| issue_ctx | input | IDX_W | Context that issued |
| can_issue | input | NUM_CTX | Per-context ready-to-issue vector |
| dirty_set | input | NUM_CTX | Per-context mark of new unsaved register state |
| spare_cycle | input | 1 | Memory port is otherwise idle this cycle |
| xfer_done | input | 1 | Background transfer of the oldest context completed |
| lri_ctx | output | IDX_W | Least recently issued context |
| dribble_req | output | 1 | Request background transfer for `lri_ctx` |
| stall_evt | output | 1 | One-cycle stall event to software |

## Verification
The bench builds the block with NUM_CTX = 8, which gives a seven-entry order list. This is small enough that random issue strobes reach every position, including moves of the oldest entry, the newest entry and middle entries, within a few thousand cycles. With eight contexts, a random `can_issue` is all zeros often enough to drive the stall machine through every state and transition. Directed sequences cover the reset order, issues by context 0, set/clear collisions, and re-arming after a pulse.

// File: rtl/lri_pkg.sv
package lri_pkg;
    typedef enum logic [1:0] {
        ST_ARMED = 2'd0,
        ST_EVENT = 2'd1,
        ST_WAIT  = 2'd2
    } stall_state_t;
endpackage

// File: rtl/lri_order_list.sv
module lri_order_list #(
    parameter int NUM_CTX = 8,
    parameter int IDX_W   = $clog2(NUM_CTX)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue_vld,
    input  logic [IDX_W-1:0] issue_ctx,
    output logic [IDX_W-1:0] lri_ctx
);
    localparam int SLOTS = NUM_CTX - 1;

    logic [SLOTS-1:0][IDX_W-1:0] order_q;
    logic [SLOTS-1:0][IDX_W-1:0] order_d;
    logic [SLOTS-1:0]            hit;
    logic [SLOTS-1:0]            passed;
    logic                        move;

    // slot 0 is the oldest, slot SLOTS-1 the newest
    genvar g;
    generate
        for (g = 0; g < SLOTS; g++) begin : g_slot
            assign hit[g] = (order_q[g] == issue_ctx);
            if (g == 0) begin : g_first
                assign passed[g] = hit[g];
            end else begin : g_rest
                assign passed[g] = passed[g-1] | hit[g];
            end
            if (g == SLOTS - 1) begin : g_tail
                assign order_d[g] = move ? issue_ctx : order_q[g];
            end else begin : g_body
                assign order_d[g] = (move && passed[g]) ? order_q[g+1] : order_q[g];
            end
        end
    endgenerate

    assign move    = issue_vld && (issue_ctx != '0) && passed[SLOTS-1];
    assign lri_ctx = order_q[0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SLOTS; i++) order_q[i] <= IDX_W'(i + 1);
        end else begin
            order_q <= order_d;
        end
    end

    AST_ISSUE_TO_NEWEST: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_vld && issue_ctx != '0 && int'(issue_ctx) < NUM_CTX) |=> (order_q[SLOTS-1] == $past(issue_ctx))); // R2
    AST_CTX0_KEEPS_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_vld && issue_ctx == '0) |=> $stable(order_q)); // R3
    AST_LRI_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        lri_ctx != '0); // R3
endmodule

// File: rtl/lri_dirty_track.sv
module lri_dirty_track #(
    parameter int NUM_CTX = 8,
    parameter int IDX_W   = $clog2(NUM_CTX)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CTX-1:0] dirty_set,
    input  logic               xfer_done,
    input  logic [IDX_W-1:0]   lri_ctx,
    output logic               lri_dirty
);
    logic [NUM_CTX-1:0] dirty_q;
    logic [NUM_CTX-1:0] dirty_d;

    genvar g;
    generate
        for (g = 0; g < NUM_CTX; g++) begin : g_flag
            if (g == 0) begin : g_kernel
                assign dirty_d[g] = 1'b0;
            end else begin : g_user
                assign dirty_d[g] = dirty_set[g] |
                                    (dirty_q[g] & ~(xfer_done && int'(lri_ctx) == g));
            end
        end
    endgenerate

    assign lri_dirty = dirty_q[lri_ctx];

    always_ff @(posedge clk) begin
        if (!rst_n) dirty_q <= '0;
        else        dirty_q <= dirty_d;
    end

    AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && !dirty_set[lri_ctx]) |=> !dirty_q[$past(lri_ctx)]); // R4
    AST_SET_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
        (dirty_set[lri_ctx] && lri_ctx != '0) |=> dirty_q[$past(lri_ctx)]); // R4
endmodule

// File: rtl/lri_stall_fsm.sv
module lri_stall_fsm
    import lri_pkg::*;
#(
    parameter int NUM_CTX = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CTX-1:0] can_issue,
    input  logic               lri_dirty,
    input  logic               issue_vld,
    output logic               stall_evt
);
    stall_state_t state_q, state_d;
    logic         blocked;

    assign blocked = (can_issue == '0) && !lri_dirty;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_ARMED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARMED: if (blocked)   state_d = ST_EVENT;
            ST_EVENT: state_d = issue_vld ? ST_ARMED : ST_WAIT;
            ST_WAIT:  if (issue_vld) state_d = ST_ARMED;
            default:  state_d = ST_ARMED;
        endcase
    end

    always_comb begin
        stall_evt = (state_q == ST_EVENT);
    end

    AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        stall_evt |=> !stall_evt); // R7
    AST_NO_REFIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && !issue_vld) |=> (state_q != ST_EVENT)); // R7
endmodule

// File: rtl/lri_ctx_tracker.sv
module lri_ctx_tracker #(
    parameter int NUM_CTX = 8,
    parameter int IDX_W   = $clog2(NUM_CTX)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               issue_vld,
    input  logic [IDX_W-1:0]   issue_ctx,
    input  logic [NUM_CTX-1:0] can_issue,
    input  logic [NUM_CTX-1:0] dirty_set,
    input  logic               spare_cycle,
    input  logic               xfer_done,
    output logic [IDX_W-1:0]   lri_ctx,
    output logic               dribble_req,
    output logic               stall_evt
);
    logic lri_dirty;

    lri_order_list #(.NUM_CTX(NUM_CTX), .IDX_W(IDX_W)) u_order (
        .clk       (clk),
        .rst_n     (rst_n),
        .issue_vld (issue_vld),
        .issue_ctx (issue_ctx),
        .lri_ctx   (lri_ctx)
    );

    lri_dirty_track #(.NUM_CTX(NUM_CTX), .IDX_W(IDX_W)) u_dirty (
        .clk       (clk),
        .rst_n     (rst_n),
        .dirty_set (dirty_set),
        .xfer_done (xfer_done),
        .lri_ctx   (lri_ctx),
        .lri_dirty (lri_dirty)
    );

    lri_stall_fsm #(.NUM_CTX(NUM_CTX)) u_stall (
        .clk       (clk),
        .rst_n     (rst_n),
        .can_issue (can_issue),
        .lri_dirty (lri_dirty),
        .issue_vld (issue_vld),
        .stall_evt (stall_evt)
    );

    assign dribble_req = spare_cycle & lri_dirty;

    AST_DRIBBLE_NEEDS_SPARE: assert property (@(posedge clk) disable iff (!rst_n)
        dribble_req |-> spare_cycle); // R5
    AST_STALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        stall_evt |-> $past(can_issue == '0 && !lri_dirty)); // R6
    AST_STALL_EXCLUDES_DRIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (can_issue == '0 && dribble_req) |=> !stall_evt); // R6
endmodule

// File: tb/lri_ctx_tracker_tb.sv
module lri_ctx_tracker_tb_top;
    localparam int N  = 8;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          issue_vld = 1'b0;
    logic [IW-1:0] issue_ctx = '0;
    logic [N-1:0]  can_issue = '1;
    logic [N-1:0]  dirty_set = '0;
    logic          spare_cycle = 1'b0;
    logic          xfer_done = 1'b0;
    logic [IW-1:0] lri_ctx;
    logic          dribble_req;
    logic          stall_evt;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    int m_order [N-1];
    bit m_dirty [N];
    int m_st;

    always #4 clk = ~clk;

    lri_ctx_tracker #(.NUM_CTX(N), .IDX_W(IW)) dut_i (
        .clk(clk), .rst_n(rst_n), .issue_vld(issue_vld), .issue_ctx(issue_ctx),
        .can_issue(can_issue), .dirty_set(dirty_set), .spare_cycle(spare_cycle),
        .xfer_done(xfer_done), .lri_ctx(lri_ctx), .dribble_req(dribble_req),
        .stall_evt(stall_evt)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic bit exp_dribble();
        return spare_cycle && m_dirty[m_order[0]];
    endfunction

    task automatic model_reset();
        for (int i = 0; i < N - 1; i++) m_order[i] = i + 1;
        for (int i = 0; i < N; i++) m_dirty[i] = 1'b0;
        m_st = 0;
    endtask

    task automatic model_clock();
        bit blocked;
        int lri;
        int p;
        lri = m_order[0];
        blocked = (can_issue == '0) && !m_dirty[lri];
        for (int i = 1; i < N; i++)
            m_dirty[i] = dirty_set[i] || (m_dirty[i] && !(xfer_done && i == lri));
        if (issue_vld && issue_ctx != 0) begin
            p = 0;
            for (int i = 0; i < N - 1; i++) if (m_order[i] == int'(issue_ctx)) p = i;
            for (int i = p; i < N - 2; i++) m_order[i] = m_order[i+1];
            m_order[N-2] = int'(issue_ctx);
        end
        case (m_st)
            0: if (blocked) m_st = 1;
            1: m_st = issue_vld ? 0 : 2;
            default: if (issue_vld) m_st = 0;
        endcase
    endtask

    task automatic step(input bit iv, input int ic, input logic [N-1:0] ci,
                        input logic [N-1:0] ds, input bit sp, input bit dn);
        @(negedge clk);
        issue_vld = iv; issue_ctx = IW'(ic); can_issue = ci;
        dirty_set = ds; spare_cycle = sp; xfer_done = dn;
        #1;
        chk(int'(lri_ctx) == m_order[0], "R2 lri order", int'(lri_ctx), m_order[0]);
        chk(lri_ctx != 0, "R3 lri never context 0", int'(lri_ctx), m_order[0]);
        chk(dribble_req == exp_dribble(), "R4/R5 dribble", int'(dribble_req), int'(exp_dribble()));
        chk(stall_evt == (m_st == 1), "R6/R7 stall event", int'(stall_evt), int'(m_st == 1));
        @(posedge clk);
        model_clock();
    endtask

    initial begin
        void'($urandom(32'd20021203));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        spare_cycle = 1'b1;
        #1;
        // R1: reset state
        chk(lri_ctx == 1, "R1 reset lri", int'(lri_ctx), 1);
        chk(dribble_req == 0, "R1 reset clean", int'(dribble_req), 0);
        chk(stall_evt == 0, "R1 reset no event", int'(stall_evt), 0);

        // R3: context 0 issue leaves order alone
        step(1, 0, '1, '0, 1, 0);
        step(0, 0, '1, '0, 1, 0);
        chk(lri_ctx == 1, "R3 ctx0 issue keeps lri", int'(lri_ctx), 1);

        // R2: oldest, middle and newest moves
        step(1, 1, '1, '0, 0, 0);
        step(1, 4, '1, '0, 0, 0);
        step(1, 2, '1, '0, 0, 0);
        step(1, 2, '1, '0, 0, 0);
        step(0, 0, '1, '0, 0, 0);
        chk(lri_ctx == 3, "R2 after moves", int'(lri_ctx), 3);

        // R4: set and clear collide on the oldest context: stays dirty
        step(0, 0, '1, 8'b0000_1000, 1, 0);
        step(0, 0, '1, 8'b0000_1000, 1, 1);
        step(0, 0, '1, '0, 1, 0);
        chk(dribble_req == 1, "R4 set wins over clear", int'(dribble_req), 1);
        // R6: dirty oldest blocks the event
        step(0, 0, '0, '0, 1, 0);
        step(0, 0, '0, '0, 1, 0);
        chk(stall_evt == 0, "R6 no event while dirty", int'(stall_evt), 0);
        // clear, then the event fires; R7 no refire until issue
        step(0, 0, '0, '0, 1, 1);
        step(0, 0, '0, '0, 0, 0);
        step(0, 0, '0, '0, 0, 0);
        step(0, 0, '0, '0, 0, 0);
        step(0, 0, '0, '0, 0, 0);
        chk(stall_evt == 0, "R7 waits for issue", int'(stall_evt), 0);
        step(1, 0, '0, 8'b0000_0001, 0, 0);
        step(0, 0, '0, '0, 0, 0);
        step(0, 0, '0, '0, 0, 0);

        // random phase
        for (int n = 0; n < 4000; n++) begin
            bit iv, sp, dn;
            int ic;
            logic [N-1:0] ci, ds;
            iv = ($urandom % 3) != 0;
            ic = $urandom % N;
            ci = (($urandom % 3) == 0) ? '0 : N'($urandom);
            ds = (($urandom % 4) == 0) ? N'(1 << ($urandom % N)) : '0;
            sp = $urandom % 2;
            dn = ($urandom % 3) == 0;
            step(iv, ic, ci, ds, sp, dn);
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual 0 expected 1 (run completed)");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule